// File: doc/BRIEF.md
# PS/2 Pointing Device Command Engine

This block is the device side of a PS/2-style mouse, seen above the wire level. The host hands it one command byte at a time. The block updates its internal settings and places every answer byte into an output queue, which a downstream serializer drains. The settings it holds are stream or remote mode, reporting enable, echo (wrap) mode, scaling, resolution, sample rate and device identity.

Motion deltas, wheel steps and button levels arrive on a separate input. The block sums them in saturating accumulators and turns them into movement packets. A packet is three bytes long, or four bytes once the host has unlocked the wheel extension. The unlock is a fixed sequence of three sample-rate settings, and it also changes the reported device identity from 0 to 3.

A single cycle can push up to five bytes into the queue. A command is accepted only while the queue has room for the longest possible answer.

Top module: `ps2_mouse_responder`

## Requirements
- R1: Each accepted command byte that is outside wrap mode and is not a parameter gets 0xFA as its first answer byte. An unknown command gets the single byte 0xFE.
- R2: 0xF3 (sample rate) and 0xE8 (resolution) each take the next byte as a parameter, whatever its value. The command byte and the parameter byte are each answered with 0xFA, and the parameter becomes the new rate or resolution.
- R3: The device identity is 0 until three consecutive rate parameters of 200, 100 and 80 arrive, and then it is 3. Command 0xF2 answers 0xFA and then the identity byte.
- R4: Command 0xE9 answers 0xFA and then three bytes: status, resolution, rate. The status bits are: bit 6 remote mode, bit 5 reporting on, bit 4 2:1 scaling, bit 2 left button, bit 1 middle button, bit 0 right button. All other bits are 0.
- R5: 0xF0 selects remote mode and 0xEA selects stream mode. 0xF4 turns reporting on and 0xF5 turns it off, but each has an effect only in stream mode. 0xE7 selects 2:1 scaling and 0xE6 selects 1:1. Each of these commands answers 0xFA.
- R6: 0xEE enters wrap mode and 0xEC leaves it. While in wrap mode, every byte except 0xEC and 0xFF is returned unchanged and has no other effect.
- R7: 0xFF answers 0xFA, 0xAA, 0x00 and restores the defaults: rate 100, resolution 2, stream mode, reporting off, 1:1 scaling, identity 0, wrap off. 0xF6 restores the same defaults and answers only 0xFA.
- R8: Packet byte 0 has bit 5 = Y sign, bit 4 = X sign, bit 3 = 1, and bits 2:0 = the button input {middle, right, left}. Bytes 1 and 2 are X and Y. With identity 3, a fourth byte carries the wheel sum, clamped to -8..7 and sign-extended.
- R9: X and Y sums saturate to the 9-bit signed range (-256..255) when a packet is formed.
- R10: A packet is emitted on its own only in stream mode with reporting on. It needs a nonzero motion or wheel sum, or a button level different from the last one sent, and room in the queue for the whole packet. With reporting off, motion only accumulates.
- R11: 0xEB answers 0xFA followed by one packet, even when there is no motion. The packet clears the sums, and so do 0xF4, 0xF5, 0xF0, 0xEA, 0xF6 and 0xFF.
- R12: When a command is accepted in the same cycle that a packet is due, the whole command answer is queued first and the packet follows after it.
- R13: cmd_ready is high only while at least five queue entries are free. Out bytes leave in order, one per cycle in which out_valid and out_ready are both high.
- R14: After reset, out_valid is low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command byte present |
| cmd_data | input | 8 | Host command or parameter byte |
| cmd_ready | output | 1 | Command byte can be accepted this cycle |
| mv_valid | input | 1 | Motion sample present |
| mv_dx | input | MV_W | Signed X delta |
| mv_dy | input | MV_W | Signed Y delta |
| mv_dz | input | WH_W | Signed wheel delta |
| btn | input | 3 | Button levels {middle, right, left} |
| out_valid | output | 1 | Answer byte available |
| out_data | output | 8 | Answer byte |
| out_ready | input | 1 | Consumer takes the byte |

## Verification
The two functions that can fall in one cycle are accepting a command and emitting a stream packet. The bench provokes the overlap by enabling reporting and injecting one motion sample. It then presents a status request in the very next cycle, which is the cycle the packet would otherwise leave. The scoreboard expects the four status bytes first and then the packet, and any reordering, loss or merged byte shows up as a mismatch. A second overlap happens when the queue is nearly full: the bench stalls the consumer and checks that command acceptance drops before any byte would be lost.

// File: rtl/ps2m_pkg.sv
// Shared constants for the pointing-device command engine.
// Assumes byte-wide host traffic; the answer burst limit is fixed by protocol.
package ps2m_pkg;
    localparam int MAXP = 5;              // longest single-cycle answer burst
    localparam logic [7:0] B_ACK   = 8'hFA;
    localparam logic [7:0] B_NAK   = 8'hFE;
    localparam logic [7:0] B_SELF  = 8'hAA;
    localparam logic [7:0] C_RESET = 8'hFF;
    localparam logic [7:0] C_DEFLT = 8'hF6;
    localparam logic [7:0] C_DIS   = 8'hF5;
    localparam logic [7:0] C_EN    = 8'hF4;
    localparam logic [7:0] C_RATE  = 8'hF3;
    localparam logic [7:0] C_ID    = 8'hF2;
    localparam logic [7:0] C_REM   = 8'hF0;
    localparam logic [7:0] C_WRON  = 8'hEE;
    localparam logic [7:0] C_WROFF = 8'hEC;
    localparam logic [7:0] C_READ  = 8'hEB;
    localparam logic [7:0] C_STRM  = 8'hEA;
    localparam logic [7:0] C_STAT  = 8'hE9;
    localparam logic [7:0] C_RES   = 8'hE8;
    localparam logic [7:0] C_SC21  = 8'hE7;
    localparam logic [7:0] C_SC11  = 8'hE6;
    typedef enum logic [1:0] {ARG_NONE, ARG_RATE, ARG_RES} arg_e;
endpackage

// File: rtl/ps2m_out_fifo.sv
// Answer queue: accepts 0..MAXP bytes per cycle, releases one per cycle.
// Assumes DEPTH is a power of two and the writer never exceeds free_cnt.
module ps2m_out_fifo
    import ps2m_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     push_cnt,
    input  logic [MAXP-1:0][7:0]           push_data,
    input  logic                           pop,
    output logic                           out_valid,
    output logic [7:0]                     out_data,
    output logic [$clog2(DEPTH+1)-1:0]     free_cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] count;
    logic          pop_ok;

    assign out_valid = (count != '0);
    assign pop_ok    = pop && out_valid;
    assign out_data  = mem[rp];
    assign free_cnt  = CW'(DEPTH) - count;

    // storage write of the burst, lane i lands at wp+i
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAXP; i++) begin
            if (i < int'(push_cnt)) mem[wp + AW'(i)] <= push_data[i];
        end
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            wp    <= wp + AW'(push_cnt);
            rp    <= rp + AW'(pop_ok);
            count <= count + CW'(push_cnt) - CW'(pop_ok);
        end
    end

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(push_cnt) <= free_cnt);
    assert_drain_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && push_cnt == 3'd0) |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/ps2m_motion.sv
// Motion accumulator and packet formatter.
// Assumes ACC_W >= 10 so that the 9-bit saturation bounds fit the sums.
module ps2m_motion #(
    parameter int MV_W  = 10,
    parameter int WH_W  = 6,
    parameter int ACC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mv_valid,
    input  logic signed [MV_W-1:0]  mv_dx,
    input  logic signed [MV_W-1:0]  mv_dy,
    input  logic signed [WH_W-1:0]  mv_dz,
    input  logic [2:0]              btn,
    input  logic                    take,
    output logic [3:0][7:0]         pkt,
    output logic                    pending
);
    localparam logic signed [ACC_W-1:0] AMAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] AMIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] HI9  = ACC_W'(255);
    localparam logic signed [ACC_W-1:0] LO9  = -ACC_W'(256);
    localparam logic signed [ACC_W-1:0] HI4  = ACC_W'(7);
    localparam logic signed [ACC_W-1:0] LO4  = -ACC_W'(8);

    logic signed [ACC_W-1:0] acc_x, acc_y, acc_z;
    logic [2:0]              btn_sent;
    logic signed [8:0]       x9, y9;
    logic signed [3:0]       z4;

    function automatic logic signed [ACC_W-1:0] sat_add(
        input logic signed [ACC_W-1:0] a, input logic signed [ACC_W-1:0] b);
        logic signed [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
        if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? AMIN : AMAX;
        return s[ACC_W-1:0];
    endfunction

    function automatic logic signed [ACC_W-1:0] clampv(
        input logic signed [ACC_W-1:0] v, input logic signed [ACC_W-1:0] lo,
        input logic signed [ACC_W-1:0] hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // accumulate samples; a take restarts the sums from the current sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_x    <= '0;
            acc_y    <= '0;
            acc_z    <= '0;
            btn_sent <= '0;
        end else begin
            acc_x <= sat_add(take ? '0 : acc_x, mv_valid ? ACC_W'(mv_dx) : '0);
            acc_y <= sat_add(take ? '0 : acc_y, mv_valid ? ACC_W'(mv_dy) : '0);
            acc_z <= sat_add(take ? '0 : acc_z, mv_valid ? ACC_W'(mv_dz) : '0);
            if (take) btn_sent <= btn;
        end
    end

    // packet formatting from saturated sums
    always_comb begin
        x9 = 9'(clampv(acc_x, LO9, HI9));
        y9 = 9'(clampv(acc_y, LO9, HI9));
        z4 = 4'(clampv(acc_z, LO4, HI4));
        pkt[0] = {2'b00, y9[8], x9[8], 1'b1, btn};
        pkt[1] = x9[7:0];
        pkt[2] = y9[7:0];
        pkt[3] = {{4{z4[3]}}, z4};
    end

    assign pending = (acc_x != '0) || (acc_y != '0) || (acc_z != '0) || (btn != btn_sent);

    assert_take_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !mv_valid) |=> (acc_x == '0 && acc_y == '0 && acc_z == '0));
endmodule

// File: rtl/ps2m_ctrl.sv
// Command decoder and device state; chooses per cycle between a command
// answer and a stream packet, the command always winning.
// Assumes free_cnt reflects the queue before this cycle's pushes.
module ps2m_ctrl
    import ps2m_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_data,
    output logic                 cmd_ready,
    input  logic [CW-1:0]        free_cnt,
    input  logic [3:0][7:0]      pkt,
    input  logic                 pkt_pending,
    input  logic [2:0]           btn,
    output logic                 take,
    output logic [2:0]           push_cnt,
    output logic [MAXP-1:0][7:0] push_data
);
    logic       remote, rep_en, wrap, scale21;
    logic [7:0] res, rate, rate_prev, dev_id;
    arg_e       arg;

    logic       remote_n, rep_n, wrap_n, scale_n;
    logic [7:0] res_n, rate_n, rate_prev_n, id_n;
    arg_e       arg_n;
    logic       fire, stream_ok;
    logic [2:0] pkt_len;
    logic [7:0] status;

    assign cmd_ready = (free_cnt >= CW'(MAXP));
    assign fire      = cmd_valid && cmd_ready;
    assign pkt_len   = (dev_id == 8'd3) ? 3'd4 : 3'd3;
    assign status    = {1'b0, remote, rep_en, scale21, 1'b0, btn[0], btn[2], btn[1]};
    assign stream_ok = !remote && rep_en && !wrap && (arg == ARG_NONE) &&
                       pkt_pending && !fire && (free_cnt >= CW'(pkt_len));

    // decode one command or parameter byte, else emit a due stream packet
    always_comb begin
        remote_n = remote;  rep_n = rep_en;  wrap_n = wrap;  scale_n = scale21;
        res_n = res;  rate_n = rate;  rate_prev_n = rate_prev;  id_n = dev_id;
        arg_n = arg;
        take = 1'b0;
        push_cnt = 3'd0;
        push_data = '0;
        push_data[0] = B_ACK;
        if (fire) begin
            push_cnt = 3'd1;
            if (wrap && cmd_data != C_WROFF && cmd_data != C_RESET) begin
                push_data[0] = cmd_data;
            end else if (arg != ARG_NONE) begin
                arg_n = ARG_NONE;
                if (arg == ARG_RES) begin
                    res_n = cmd_data;
                end else begin
                    rate_n = cmd_data;
                    rate_prev_n = rate;
                    if (rate_prev == 8'd200 && rate == 8'd100 && cmd_data == 8'd80)
                        id_n = 8'd3;
                end
            end else begin
                case (cmd_data)
                    C_RESET, C_DEFLT: begin
                        remote_n = 1'b0;  rep_n = 1'b0;  wrap_n = 1'b0;  scale_n = 1'b0;
                        res_n = 8'd2;  rate_n = 8'd100;  rate_prev_n = 8'd0;  id_n = 8'd0;
                        take = 1'b1;
                        if (cmd_data == C_RESET) begin
                            push_cnt = 3'd3;
                            push_data[1] = B_SELF;
                            push_data[2] = 8'h00;
                        end
                    end
                    C_DIS:   begin take = 1'b1; if (!remote) rep_n = 1'b0; end
                    C_EN:    begin take = 1'b1; if (!remote) rep_n = 1'b1; end
                    C_RATE:  arg_n = ARG_RATE;
                    C_RES:   arg_n = ARG_RES;
                    C_ID:    begin push_cnt = 3'd2; push_data[1] = dev_id; end
                    C_REM:   begin take = 1'b1; remote_n = 1'b1; end
                    C_STRM:  begin take = 1'b1; remote_n = 1'b0; end
                    C_WRON:  wrap_n = 1'b1;
                    C_WROFF: wrap_n = 1'b0;
                    C_SC21:  scale_n = 1'b1;
                    C_SC11:  scale_n = 1'b0;
                    C_READ: begin
                        take = 1'b1;
                        push_cnt = 3'd1 + pkt_len;
                        push_data[1] = pkt[0];
                        push_data[2] = pkt[1];
                        push_data[3] = pkt[2];
                        push_data[4] = pkt[3];
                    end
                    C_STAT: begin
                        push_cnt = 3'd4;
                        push_data[1] = status;
                        push_data[2] = res;
                        push_data[3] = rate;
                    end
                    default: push_data[0] = B_NAK;
                endcase
            end
        end else if (stream_ok) begin
            take = 1'b1;
            push_cnt = pkt_len;
            push_data[0] = pkt[0];
            push_data[1] = pkt[1];
            push_data[2] = pkt[2];
            push_data[3] = pkt[3];
        end
    end

    // device state registers, reset to protocol defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remote <= 1'b0;  rep_en <= 1'b0;  wrap <= 1'b0;  scale21 <= 1'b0;
            res <= 8'd2;  rate <= 8'd100;  rate_prev <= 8'd0;  dev_id <= 8'd0;
            arg <= ARG_NONE;
        end else begin
            remote <= remote_n;  rep_en <= rep_n;  wrap <= wrap_n;  scale21 <= scale_n;
            res <= res_n;  rate <= rate_n;  rate_prev <= rate_prev_n;  dev_id <= id_n;
            arg <= arg_n;
        end
    end

    assert_id_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_id == 8'd0) || (dev_id == 8'd3));
    assert_stream_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_cnt != 3'd0 && !fire) |-> (!remote && rep_en && !wrap));
    assert_answer_each_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> push_cnt != 3'd0);
    assert_cmd_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wrap && arg == ARG_NONE && cmd_data == C_STAT) |-> push_cnt == 3'd4);
endmodule

// File: rtl/ps2_mouse_responder.sv
// Top of the pointing-device command engine: decoder, motion accumulator
// and answer queue. Assumes host bytes are already deserialized.
module ps2_mouse_responder #(
    parameter int DEPTH = 16,
    parameter int MV_W  = 10,
    parameter int WH_W  = 6,
    parameter int ACC_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [7:0]             cmd_data,
    output logic                   cmd_ready,
    input  logic                   mv_valid,
    input  logic signed [MV_W-1:0] mv_dx,
    input  logic signed [MV_W-1:0] mv_dy,
    input  logic signed [WH_W-1:0] mv_dz,
    input  logic [2:0]             btn,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    input  logic                   out_ready
);
    localparam int CW = $clog2(DEPTH+1);

    logic [CW-1:0]                  free_cnt;
    logic [3:0][7:0]                pkt;
    logic                           pending, take;
    logic [2:0]                     push_cnt;
    logic [ps2m_pkg::MAXP-1:0][7:0] push_data;

    ps2m_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .free_cnt(free_cnt), .pkt(pkt), .pkt_pending(pending),
        .btn(btn), .take(take), .push_cnt(push_cnt), .push_data(push_data)
    );

    ps2m_motion #(.MV_W(MV_W), .WH_W(WH_W), .ACC_W(ACC_W)) u_motion (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dx(mv_dx), .mv_dy(mv_dy),
        .mv_dz(mv_dz), .btn(btn), .take(take), .pkt(pkt), .pending(pending)
    );

    ps2m_out_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_cnt(push_cnt), .push_data(push_data),
        .pop(out_ready), .out_valid(out_valid), .out_data(out_data), .free_cnt(free_cnt)
    );
endmodule

// File: tb/ps2_mouse_responder_test.sv
// Scoreboard bench: tasks queue expected bytes, a monitor compares output.
module ps2_mouse_responder_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [7:0]        cmd_data = 8'h00;
    logic              cmd_ready;
    logic              mv_valid = 1'b0;
    logic signed [9:0] mv_dx = '0, mv_dy = '0;
    logic signed [5:0] mv_dz = '0;
    logic [2:0]        btn = 3'b000;
    logic              out_valid;
    logic [7:0]        out_data;
    logic              out_ready = 1'b1;

    int checks = 0;
    int bad = 0;
    logic [7:0] expq[$];
    string      tagq[$];

    always #5 clk = ~clk;

    ps2_mouse_responder uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .mv_valid(mv_valid), .mv_dx(mv_dx), .mv_dy(mv_dy),
        .mv_dz(mv_dz), .btn(btn), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    task automatic ex(input logic [7:0] b, input string r);
        expq.push_back(b);
        tagq.push_back(r);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp_v, input string r);
        checks++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", r, act, exp_v);
        end
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = c;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic move(input int dx, input int dy, input int dz);
        @(negedge clk);
        mv_valid = 1'b1;
        mv_dx = 10'(dx);
        mv_dy = 10'(dy);
        mv_dz = 6'(dz);
        @(negedge clk);
        mv_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: compare each released byte with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) begin
                checks++;
                bad++;
                $display("FAIL unexpected actual=%02h expected=none", out_data);
            end else begin
                chk(out_data, expq.pop_front(), tagq.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({7'd0, out_valid}, 8'd0, "R14 out_valid");
        chk({7'd0, cmd_ready}, 8'd1, "R14 cmd_ready");

        ex(8'hFA, "R3"); ex(8'h00, "R3 id0"); send(8'hF2);
        ex(8'hFA, "R4"); ex(8'h00, "R4 status"); ex(8'h02, "R4 res"); ex(8'h64, "R4 rate");
        send(8'hE9);
        ex(8'hFA, "R2"); ex(8'hFA, "R2 arg"); send(8'hF3); send(8'd200);
        ex(8'hFA, "R2"); ex(8'hFA, "R2 arg"); send(8'hF3); send(8'd100);
        ex(8'hFA, "R2"); ex(8'hFA, "R2 arg"); send(8'hF3); send(8'd80);
        ex(8'hFA, "R3"); ex(8'h03, "R3 id3"); send(8'hF2);
        ex(8'hFA, "R4"); ex(8'h00, "R4 status"); ex(8'h02, "R4 res"); ex(8'h50, "R4 rate");
        send(8'hE9);
        drain();

        // R5 remote mode, scaling, reporting ignored in remote
        ex(8'hFA, "R2"); ex(8'hFA, "R2 res arg"); send(8'hE8); send(8'h03);
        ex(8'hFA, "R5"); send(8'hE7);
        ex(8'hFA, "R5"); send(8'hF0);
        ex(8'hFA, "R5"); send(8'hF4);
        ex(8'hFA, "R5"); ex(8'h50, "R5 remote status"); ex(8'h03, "R2 res"); ex(8'h50, "R5 rate");
        send(8'hE9);
        ex(8'hFA, "R5"); send(8'hEA);
        ex(8'hFA, "R5"); send(8'hF4);
        ex(8'hFA, "R5"); send(8'hE6);
        ex(8'hFA, "R5"); ex(8'h20, "R5 stream status"); ex(8'h03, "R5 res"); ex(8'h50, "R5 rate");
        send(8'hE9);
        drain();

        // R8 stream packet with wheel byte
        ex(8'h28, "R8 b0"); ex(8'h05, "R8 x"); ex(8'hFD, "R8 y"); ex(8'h02, "R8 z");
        move(5, -3, 2);
        drain();
        // R9 saturation both directions
        ex(8'h28, "R9 b0"); ex(8'hFF, "R9 x"); ex(8'h00, "R9 y"); ex(8'hF8, "R9 z");
        move(300, -400, -20);
        drain();
        ex(8'h18, "R9 b0"); ex(8'h00, "R9 x"); ex(8'hFF, "R9 y"); ex(8'h07, "R9 z");
        move(-300, 300, 9);
        drain();
        // R10 button change alone
        ex(8'h0D, "R10 b0"); ex(8'h00, "R10 x"); ex(8'h00, "R10 y"); ex(8'h00, "R10 z");
        @(negedge clk); btn = 3'b101;
        drain();

        // R12 command and due packet in the same cycle
        ex(8'hFA, "R12"); ex(8'h26, "R12 status"); ex(8'h03, "R12 res"); ex(8'h50, "R12 rate");
        ex(8'h0D, "R12 b0"); ex(8'h01, "R12 x"); ex(8'h00, "R12 y"); ex(8'h00, "R12 z");
        @(negedge clk);
        mv_valid = 1'b1; mv_dx = 10'sd1; mv_dy = '0; mv_dz = '0;
        @(negedge clk);
        mv_valid = 1'b0; cmd_valid = 1'b1; cmd_data = 8'hE9;
        @(negedge clk);
        cmd_valid = 1'b0;
        drain();

        // R10 reporting off accumulates; R11 forced read and clear
        ex(8'hFA, "R5"); send(8'hF5);
        move(4, 0, 0);
        ex(8'hFA, "R11"); ex(8'h0D, "R11 b0"); ex(8'h04, "R10 held x"); ex(8'h00, "R11 y"); ex(8'h00, "R11 z");
        send(8'hEB);
        ex(8'hFA, "R11"); ex(8'h0D, "R11 b0"); ex(8'h00, "R11 cleared x"); ex(8'h00, "R11 y"); ex(8'h00, "R11 z");
        send(8'hEB);
        drain();

        // R6 wrap echo
        ex(8'hFA, "R6"); send(8'hEE);
        ex(8'h12, "R6 echo"); send(8'h12);
        ex(8'hF2, "R6 echo cmd"); send(8'hF2);
        ex(8'hFA, "R6 leave"); send(8'hEC);
        ex(8'hFA, "R6"); ex(8'h03, "R6 id kept"); send(8'hF2);
        // R1 unknown
        ex(8'hFE, "R1 nak"); send(8'h55);
        drain();

        // R7 reset and defaults
        ex(8'hFA, "R7"); ex(8'hAA, "R7 selftest"); ex(8'h00, "R7 id"); send(8'hFF);
        ex(8'hFA, "R7"); ex(8'h00, "R7 id0"); send(8'hF2);
        ex(8'hFA, "R7"); ex(8'h06, "R7 status"); ex(8'h02, "R7 res"); ex(8'h64, "R7 rate");
        send(8'hE9);
        ex(8'hFA, "R8"); ex(8'h0D, "R8 b0"); ex(8'h00, "R8 x"); ex(8'h00, "R8 short");
        send(8'hEB);
        ex(8'hFA, "R2"); ex(8'hFA, "R2 arg"); send(8'hF3); send(8'd40);
        ex(8'hFA, "R7 F6"); send(8'hF6);
        ex(8'hFA, "R7"); ex(8'h06, "R7 status"); ex(8'h02, "R7 res"); ex(8'h64, "R7 rate back");
        send(8'hE9);
        drain();

        // R13 back-pressure
        @(posedge clk); #1 out_ready = 1'b0;
        for (int k = 0; k < 6; k++) begin
            ex(8'hFA, "R13"); ex(8'h00, "R13 id");
            send(8'hF2);
        end
        @(negedge clk);
        chk({7'd0, cmd_ready}, 8'd0, "R13 ready low");
        @(posedge clk); #1 out_ready = 1'b1;
        drain();

        checks++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL R13 leftover actual=%0d expected=0", expq.size());
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule